// File: doc/BRIEF.md
# Address-space-tagged translation buffer

The block is a fully associative page-translation cache. Each slot stores a virtual page number, a physical page number, an address-space number, a global flag, and two per-privilege-mode masks: one enabling reads and one enabling writes. A lookup is purely combinational. It presents a page number and the current address-space number, and it returns a hit flag, the physical page and the two permission masks in the same cycle.

New translations enter through a valid/ready insert stream. An accepted insert always writes the slot named by a rotating replacement pointer and then moves that pointer on by one. The insert stream is held off with ready low in any cycle that carries a flush request. A held-off beat has no effect, and the producer keeps it on the bus until ready returns. Three flush commands are provided: clear every slot, clear only the non-global slots, and clear the slots that match one page. An indexed read port always shows the slot under the replacement pointer. It can step the pointer without writing anything, so software-style refill sequences can inspect the victim and skip it. Pages are 2^PAGE_SHIFT bytes, and the page number is the virtual address above that shift.

Top module: `asn_tlb`

## Requirements
- R1: After reset no lookup hits, the replacement pointer `idx_slot` is 0 and `idx_valid` is 0.
- R2: A lookup hits only on a valid slot whose page tag equals `lk_vpn` and whose global flag is set or whose stored address-space number equals `lk_asn`. On a hit, `lk_ppn`, `lk_rd_en` and `lk_wr_en` are that slot's fields. On a miss they are all zero.
- R3: When more than one slot satisfies R2, the slot with the lowest index supplies the outputs.
- R4: An accepted insert writes the slot at `idx_slot` and marks it valid. Its tag is `ins_va[VA_W-1:PAGE_SHIFT]`, and the offset bits below `PAGE_SHIFT` are ignored. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R5: `ins_ready` is low in any cycle in which `flush_all`, `flush_proc` or `flush_addr` is high. An insert offered in such a cycle writes no slot and does not move the pointer.
- R6: `flush_all` invalidates every slot and sets the pointer to 0 at the next clock edge.
- R7: `flush_proc` invalidates every slot whose global flag is clear and keeps the global slots.
- R8: `flush_addr` invalidates every slot whose tag equals `flush_va[VA_W-1:PAGE_SHIFT]` and that is global or holds `flush_asn`. All other slots are kept.
- R9: The `idx_*` outputs show the slot at the pointer. `idx_adv` advances the pointer by one with wrap. If an insert and `idx_adv` occur in the same cycle, the pointer still advances by exactly one.
- R10: A lookup made in the same cycle as a flush sees the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_vpn | input | VA_W-PAGE_SHIFT | Page number to translate |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup found a matching slot |
| lk_ppn | output | PPN_W | Physical page of the matching slot |
| lk_rd_en | output | MODES | Read-enable mask per privilege mode |
| lk_wr_en | output | MODES | Write-enable mask per privilege mode |
| ins_valid | input | 1 | Insert beat offered |
| ins_ready | output | 1 | Insert beat can be taken this cycle |
| ins_va | input | VA_W | Virtual address of the new translation |
| ins_asn | input | ASN_W | Address-space number of the new translation |
| ins_global | input | 1 | New translation matches any address space |
| ins_ppn | input | PPN_W | Physical page of the new translation |
| ins_rd_en | input | MODES | Read-enable mask of the new translation |
| ins_wr_en | input | MODES | Write-enable mask of the new translation |
| flush_all | input | 1 | Invalidate all slots and reset the pointer |
| flush_proc | input | 1 | Invalidate all non-global slots |
| flush_addr | input | 1 | Invalidate slots matching one page |
| flush_va | input | VA_W | Address whose page is flushed |
| flush_asn | input | ASN_W | Address-space number for the page flush |
| idx_adv | input | 1 | Step the replacement pointer |
| idx_slot | output | log2(ENTRIES) | Current replacement pointer |
| idx_valid | output | 1 | Valid flag of the slot at the pointer |
| idx_vpn | output | VA_W-PAGE_SHIFT | Tag of the slot at the pointer |
| idx_asn | output | ASN_W | Address-space number of the slot at the pointer |
| idx_global | output | 1 | Global flag of the slot at the pointer |
| idx_ppn | output | PPN_W | Physical page of the slot at the pointer |
| idx_rd_en | output | MODES | Read mask of the slot at the pointer |
| idx_wr_en | output | MODES | Write mask of the slot at the pointer |

## Verification
Several properties are checked on every clock edge: the lowest-index choice among matching slots, the emptying and pointer reset after a full flush, the removal of non-global or page-matching slots after the selective flushes, the pointer step with wrap, and the pointer holding while an insert is stalled. The bench scenarios are needed for the rest. These are the hit rule swept over a grid of page and address-space values, the value of every returned field, the ignored page offset, and the fact that a lookup in the same cycle as a flush still sees the old contents. The same holds for the combined effect of an insert and a manual step.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  // Next value of a rotating slot pointer of a table with n slots.
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/tlb_slot.sv
`timescale 1ns/1ps
module tlb_slot #(
  parameter int VPN_W = 11,
  parameter int PPN_W = 12,
  parameter int ASN_W = 4,
  parameter int MODES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VPN_W-1:0] load_vpn,
  input  logic [ASN_W-1:0] load_asn,
  input  logic             load_glob,
  input  logic [PPN_W-1:0] load_ppn,
  input  logic [MODES-1:0] load_rd,
  input  logic [MODES-1:0] load_wr,
  input  logic             clr_all,
  input  logic             clr_proc,
  input  logic             clr_addr,
  input  logic [VPN_W-1:0] clr_vpn,
  input  logic [ASN_W-1:0] clr_asn,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [ASN_W-1:0] q_asn,
  output logic             q_match,
  output logic             o_valid,
  output logic             o_glob,
  output logic [VPN_W-1:0] o_vpn,
  output logic [ASN_W-1:0] o_asn,
  output logic [PPN_W-1:0] o_ppn,
  output logic [MODES-1:0] o_rd,
  output logic [MODES-1:0] o_wr
);
  logic addr_match, kill;

  always_comb begin
    q_match    = o_valid && (o_vpn == q_vpn) && (o_glob || (o_asn == q_asn));
    addr_match = o_valid && (o_vpn == clr_vpn) && (o_glob || (o_asn == clr_asn));
    kill       = clr_all || (clr_proc && !o_glob) || (clr_addr && addr_match);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_glob  <= 1'b0;
      o_vpn   <= '0;
      o_asn   <= '0;
      o_ppn   <= '0;
      o_rd    <= '0;
      o_wr    <= '0;
    end else if (kill) begin
      o_valid <= 1'b0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_glob  <= load_glob;
      o_vpn   <= load_vpn;
      o_asn   <= load_asn;
      o_ppn   <= load_ppn;
      o_rd    <= load_rd;
      o_wr    <= load_wr;
    end
  end

  // R7: a non-global slot does not survive a process flush
  a_r7_proc_kill: assert property (@(posedge clk) disable iff (rst)
    (clr_proc && !o_glob) |=> !o_valid);
  // R8: a slot matching the flushed page is gone afterwards
  a_r8_addr_kill: assert property (@(posedge clk) disable iff (rst)
    (clr_addr && addr_match) |=> !o_valid);
  // R4: a load leaves a valid slot tagged with the loaded page
  a_r4_load_tag: assert property (@(posedge clk) disable iff (rst)
    (load && !clr_all && !clr_proc && !clr_addr) |=> (o_valid && o_vpn == $past(load_vpn)));
endmodule

// File: rtl/tlb_first.sv
`timescale 1ns/1ps
module tlb_first #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_rotor.sv
`timescale 1ns/1ps
module tlb_rotor #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero,
  input  logic          step,
  output logic [IW-1:0] ptr
);
  import tlb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || zero)
      ptr <= '0;
    else if (step)
      ptr <= IW'(wrap_next(int'(ptr), N));
  end

  // R6: a zero request lands the pointer on slot 0
  a_r6_ptr_zero: assert property (@(posedge clk) disable iff (rst)
    zero |=> (ptr == '0));
  // R9: one step moves exactly one slot, wrapping at the end
  a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (step && !zero) |=> (ptr == (($past(ptr) == IW'(N - 1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: rtl/asn_tlb.sv
`timescale 1ns/1ps
module asn_tlb #(
  parameter int ENTRIES    = 8,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 20,
  parameter int ASN_W      = 8,
  parameter int MODES      = 4,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int IW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             flush_all,
  input  logic             flush_proc,
  input  logic             flush_addr,
  input  logic [VA_W-1:0]  flush_va,
  input  logic [ASN_W-1:0] flush_asn,
  input  logic             idx_adv,
  output logic [IW-1:0]    idx_slot,
  output logic             idx_valid,
  output logic [VPN_W-1:0] idx_vpn,
  output logic [ASN_W-1:0] idx_asn,
  output logic             idx_global,
  output logic [PPN_W-1:0] idx_ppn,
  output logic [MODES-1:0] idx_rd_en,
  output logic [MODES-1:0] idx_wr_en
);
  logic               flush_any, ins_fire;
  logic [ENTRIES-1:0] hit_vec, valid_vec, glob_vec;
  logic [IW-1:0]      lk_slot;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [ASN_W-1:0]   e_asn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [MODES-1:0]   e_rd  [ENTRIES];
  logic [MODES-1:0]   e_wr  [ENTRIES];

  assign flush_any = flush_all || flush_proc || flush_addr;
  assign ins_ready = !flush_any;
  assign ins_fire  = ins_valid && ins_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .load     (ins_fire && (idx_slot == IW'(g))),
      .load_vpn (ins_va[VA_W-1:PAGE_SHIFT]),
      .load_asn (ins_asn),
      .load_glob(ins_global),
      .load_ppn (ins_ppn),
      .load_rd  (ins_rd_en),
      .load_wr  (ins_wr_en),
      .clr_all  (flush_all),
      .clr_proc (flush_proc),
      .clr_addr (flush_addr),
      .clr_vpn  (flush_va[VA_W-1:PAGE_SHIFT]),
      .clr_asn  (flush_asn),
      .q_vpn    (lk_vpn),
      .q_asn    (lk_asn),
      .q_match  (hit_vec[g]),
      .o_valid  (valid_vec[g]),
      .o_glob   (glob_vec[g]),
      .o_vpn    (e_vpn[g]),
      .o_asn    (e_asn[g]),
      .o_ppn    (e_ppn[g]),
      .o_rd     (e_rd[g]),
      .o_wr     (e_wr[g])
    );
  end

  tlb_first #(.N(ENTRIES), .IW(IW)) u_first (
    .req  (hit_vec),
    .found(lk_hit),
    .idx  (lk_slot)
  );

  tlb_rotor #(.N(ENTRIES), .IW(IW)) u_rotor (
    .clk (clk),
    .rst (rst),
    .zero(flush_all),
    .step(ins_fire || idx_adv),
    .ptr (idx_slot)
  );

  always_comb begin
    lk_ppn     = lk_hit ? e_ppn[lk_slot] : '0;
    lk_rd_en   = lk_hit ? e_rd[lk_slot]  : '0;
    lk_wr_en   = lk_hit ? e_wr[lk_slot]  : '0;
    idx_valid  = valid_vec[idx_slot];
    idx_global = glob_vec[idx_slot];
    idx_vpn    = e_vpn[idx_slot];
    idx_asn    = e_asn[idx_slot];
    idx_ppn    = e_ppn[idx_slot];
    idx_rd_en  = e_rd[idx_slot];
    idx_wr_en  = e_wr[idx_slot];
  end

  // R3: the chosen slot matches and no lower slot does
  a_r3_lowest: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (hit_vec[lk_slot] &&
               ((hit_vec & ((ENTRIES'(1) << lk_slot) - ENTRIES'(1))) == '0)));
  // R6: nothing is valid after a full flush
  a_r6_empty: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_vec == '0));
  // R7: only global slots remain valid after a process flush
  a_r7_only_global: assert property (@(posedge clk) disable iff (rst)
    flush_proc |=> ((valid_vec & ~glob_vec) == '0));
  // R5: a stalled insert leaves the pointer where it was
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    ((flush_proc || flush_addr) && !flush_all && !idx_adv) |=> $stable(idx_slot));
endmodule

// File: tb/asn_tlb_test.sv
`timescale 1ns/1ps
module asn_tlb_test;
  localparam int EN = 4, VA = 24, PS = 13, PW = 12, AW = 4, MD = 4;
  localparam int VW = VA - PS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asn = '0;
  logic lk_hit;
  logic [PW-1:0] lk_ppn;
  logic [MD-1:0] lk_rd_en, lk_wr_en;
  logic ins_valid = 1'b0, ins_ready, ins_global = 1'b0;
  logic [VA-1:0] ins_va = '0;
  logic [AW-1:0] ins_asn = '0;
  logic [PW-1:0] ins_ppn = '0;
  logic [MD-1:0] ins_rd_en = '0, ins_wr_en = '0;
  logic flush_all = 1'b0, flush_proc = 1'b0, flush_addr = 1'b0;
  logic [VA-1:0] flush_va = '0;
  logic [AW-1:0] flush_asn = '0;
  logic idx_adv = 1'b0;
  logic [1:0] idx_slot;
  logic idx_valid, idx_global;
  logic [VW-1:0] idx_vpn;
  logic [AW-1:0] idx_asn;
  logic [PW-1:0] idx_ppn;
  logic [MD-1:0] idx_rd_en, idx_wr_en;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  asn_tlb #(.ENTRIES(EN), .VA_W(VA), .PAGE_SHIFT(PS), .PPN_W(PW), .ASN_W(AW), .MODES(MD)) uut (
    .clk(clk), .rst(rst),
    .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_va(ins_va), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_ppn(ins_ppn), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
    .flush_all(flush_all), .flush_proc(flush_proc), .flush_addr(flush_addr),
    .flush_va(flush_va), .flush_asn(flush_asn),
    .idx_adv(idx_adv), .idx_slot(idx_slot), .idx_valid(idx_valid), .idx_vpn(idx_vpn),
    .idx_asn(idx_asn), .idx_global(idx_global), .idx_ppn(idx_ppn),
    .idx_rd_en(idx_rd_en), .idx_wr_en(idx_wr_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a);
    @(negedge clk);
    lk_vpn = v;
    lk_asn = a;
    #1;
  endtask

  task automatic put(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic g,
                     input logic [PW-1:0] p, input logic [MD-1:0] r, input logic [MD-1:0] w,
                     input logic adv);
    @(negedge clk);
    ins_valid  = 1'b1;
    ins_va     = {v, 13'h0ABC};
    ins_asn    = a;
    ins_global = g;
    ins_ppn    = p;
    ins_rd_en  = r;
    ins_wr_en  = w;
    idx_adv    = adv;
    @(negedge clk);
    ins_valid  = 1'b0;
    idx_adv    = 1'b0;
  endtask

  task automatic step_ptr();
    @(negedge clk);
    idx_adv = 1'b1;
    @(negedge clk);
    idx_adv = 1'b0;
  endtask

  // Expected outcome of the first fill: slot i holds page 16+i, asn i,
  // global only for i==3, ppn 256+7i, read mask 1<<i, write mask its complement.
  task automatic sweep(input string tag, input logic only_global);
    for (int v = 15; v <= 20; v++) begin
      for (int a = 0; a <= 4; a++) begin
        int i;
        logic eh;
        logic [PW-1:0] ep;
        logic [MD-1:0] er, ew;
        i  = v - 16;
        eh = (i >= 0 && i < 4) && (i == 3 || (!only_global && a == i));
        ep = eh ? PW'(256 + 7 * i) : '0;
        er = eh ? MD'(1 << i) : '0;
        ew = eh ? MD'(~(1 << i)) : '0;
        look(VW'(v), AW'(a));
        chk({tag, " hit"}, lk_hit, eh);
        chk({tag, " ppn"}, lk_ppn, ep);
        chk({tag, " rd"}, lk_rd_en, er);
        chk({tag, " wr"}, lk_wr_en, ew);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    look(11'h10, 4'h0);
    chk("R1 hit", lk_hit, 0);
    chk("R1 slot", idx_slot, 0);
    chk("R1 valid", idx_valid, 0);

    // R4: fill, pointer walks and wraps
    for (int i = 0; i < EN; i++) begin
      put(VW'(16 + i), AW'(i), (i == 3), PW'(256 + 7 * i), MD'(1 << i), MD'(~(1 << i)), 1'b0);
      chk("R4 ptr", idx_slot, (i + 1) % EN);
    end
    // R2: sweep of pages and address spaces
    sweep("R2", 1'b0);

    // R9: indexed view and stepping
    chk("R9 vpn", idx_vpn, 16);
    chk("R9 ppn", idx_ppn, 256);
    chk("R9 valid", idx_valid, 1);
    step_ptr();
    chk("R9 step", idx_slot, 1);
    chk("R9 ppn1", idx_ppn, 263);
    chk("R9 asn1", idx_asn, 1);
    step_ptr();
    step_ptr();
    step_ptr();
    chk("R9 wrap", idx_slot, 0);
    put(11'h10, 4'h0, 1'b0, 12'd256, 4'b0001, 4'b1110, 1'b1);
    chk("R9 ins+adv", idx_slot, 1);

    // R10 and R7: lookup beside a process flush sees old contents
    @(negedge clk);
    flush_proc = 1'b1;
    lk_vpn = 11'h10;
    lk_asn = 4'h0;
    #1;
    chk("R10 hit", lk_hit, 1);
    chk("R10 ppn", lk_ppn, 256);
    @(negedge clk);
    flush_proc = 1'b0;
    sweep("R7", 1'b1);
    chk("R7 ptr kept", idx_slot, 1);

    // R6: full flush
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    chk("R6 ptr", idx_slot, 0);
    chk("R6 valid", idx_valid, 0);
    look(11'h13, 4'h2);
    chk("R6 global gone", lk_hit, 0);

    // R3: overlapping matches, lowest index wins
    put(11'h20, 4'h1, 1'b0, 12'h0A0, 4'h1, 4'h1, 1'b0);
    put(11'h20, 4'h2, 1'b0, 12'h0A1, 4'h2, 4'h2, 1'b0);
    put(11'h20, 4'h3, 1'b1, 12'h0A2, 4'h4, 4'h4, 1'b0);
    put(11'h21, 4'h1, 1'b0, 12'h0A3, 4'h8, 4'h8, 1'b0);
    chk("R4 wrap", idx_slot, 0);
    look(11'h20, 4'h2);
    chk("R3 asn2", lk_ppn, 12'h0A1);
    look(11'h20, 4'h1);
    chk("R3 asn1", lk_ppn, 12'h0A0);
    look(11'h20, 4'h5);
    chk("R3 global", lk_ppn, 12'h0A2);

    // R8: page flush for asn 1 removes slot 0 and the global slot 2
    @(negedge clk);
    flush_addr = 1'b1;
    flush_va   = {11'h20, 13'h1234};
    flush_asn  = 4'h1;
    @(negedge clk);
    flush_addr = 1'b0;
    look(11'h20, 4'h2);
    chk("R8 kept hit", lk_hit, 1);
    chk("R8 kept ppn", lk_ppn, 12'h0A1);
    look(11'h20, 4'h1);
    chk("R8 asn1 gone", lk_hit, 0);
    look(11'h20, 4'h5);
    chk("R8 global gone", lk_hit, 0);
    look(11'h21, 4'h1);
    chk("R8 other page", lk_ppn, 12'h0A3);

    // R5: insert stalled by a flush
    @(negedge clk);
    flush_addr = 1'b1;
    flush_va   = {11'h7FF, 13'h0};
    ins_valid  = 1'b1;
    ins_va     = {11'h55, 13'h0};
    ins_ppn    = 12'h0EE;
    #1;
    chk("R5 ready low", ins_ready, 0);
    @(negedge clk);
    flush_addr = 1'b0;
    ins_valid  = 1'b0;
    #1;
    chk("R5 ready back", ins_ready, 1);
    chk("R5 ptr held", idx_slot, 0);
    look(11'h55, 4'h0);
    chk("R5 not written", lk_hit, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule